// File: doc/BRIEF.md
# Time-Shared Radix-4 64-Point Inverse FFT

This block turns one frequency-domain symbol of 64 complex fixed-point samples into 64 time-domain samples. The whole symbol arrives at once on a wide input port under a ready/valid handshake. The result leaves the same way on a wide output port. Inside, a single radix-4 butterfly does all the arithmetic. It is reused for the 16 butterflies of each of three stages, so one symbol takes 48 butterfly cycles.

A stage counter (0..2) and a butterfly counter (0..15) drive four 16-way operand selectors. The same counters drive four result steering paths into a 64-entry result register. They also index a twiddle generator that is built from a 17-entry quarter-wave sine table. When the butterfly counter reaches 15, the merged results are reordered by a fixed radix-4 permutation and written back into the symbol buffer. The buffer's 64 two-way selectors choose between a fresh input symbol (loaded in a permuted order) and recirculated data. After the last stage, the results go to the output register in natural time order.

Each butterfly output is divided by 4 with an arithmetic right shift of 2 bits. The whole transform therefore computes (1/64)·Σ X[k]·e^{+j2πnk/64}. The input port deasserts ready while a symbol is in flight. If the previous result has not been taken, the last butterfly waits.

Top module: `fold4_ifft64`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A symbol is accepted on a clock edge where in_valid and in_ready are both 1. From the next cycle, in_ready stays 0 until that symbol completes.
- R3: in_valid pulses and in_data values presented while in_ready is 0 are ignored. They do not change the result of the symbol in flight.
- R4: If the output register is free, out_valid rises on the 48th clock edge after the accepting edge.
- R5: Sample k sits in bits [32k+31:32k] of a port: the real part is the upper 16 bits and the imaginary part is the lower 16 bits, both two's complement. Output sample n equals (1/64)·Σ_k X[k]·e^{+j2πnk/64}, within ±3 LSB on each part, with n in natural order.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data keeps its value.
- R7: If a symbol finishes while the previous result is still waiting, the final butterfly stalls. During the stall, in_ready stays 0 and out_valid stays 1. The new result is presented on the edge after out_ready is seen high.
- R8: An edge with out_valid and out_ready both 1 clears out_valid, unless a new symbol completes on that same edge.
- R9: Each of the three stages scales by 1/4. A single nonzero bin X[0]=(A,0) therefore yields A/64 in every output sample.
- R10: in_ready returns to 1 on the edge where a symbol completes, so a new symbol can be accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input symbol present |
| in_ready | output | 1 | Engine idle, symbol can be taken |
| in_data | input | 2048 | 64 frequency-domain samples, 32 bits each |
| out_valid | output | 1 | Result symbol present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 2048 | 64 time-domain samples, 32 bits each |

## Verification
The embedded properties check the handshake rules on every cycle:
- in_ready is low whenever a symbol is in flight.
- A completion is followed by out_valid and by in_ready.
- A held result keeps its data.
- A stalled final butterfly leaves the engine busy.
- A taken result clears out_valid.

Only the bench's scenarios can show numeric correctness against a real-valued DFT, across these cases:
- an impulse, a pure tone, pseudo-random symbols and an all-zero symbol;
- input ignored while busy;
- back-to-back symbols;
- a completion that waits behind an untaken result.

// File: rtl/fold4_ifft_pkg.sv
package fold4_ifft_pkg;
  localparam int RADIX = 4;
  localparam int NSTG  = 3;
  localparam int NPT   = RADIX ** NSTG;
  localparam int NBF   = NPT / RADIX;
  localparam int IDXW  = $clog2(NBF);
  localparam int STGW  = $clog2(NSTG);
  localparam int LANEW = $clog2(RADIX);
  localparam int EXPW  = $clog2(NPT);
  localparam int DW    = 16;
  localparam int CW    = 16;
  localparam int CFRAC = 14;
  localparam int SW    = 2 * DW;
  localparam int BUSW  = NPT * SW;
  localparam int LAT   = NSTG * NBF;

  typedef struct packed {
    logic signed [DW-1:0] re;
    logic signed [DW-1:0] im;
  } cplx_t;

  // sin(pi*r/32) in Q1.14, r = 0..16
  function automatic logic signed [CW-1:0] quarter_sin(input logic [4:0] r);
    case (r)
      5'd0:  return CW'(0);
      5'd1:  return CW'(1606);
      5'd2:  return CW'(3196);
      5'd3:  return CW'(4756);
      5'd4:  return CW'(6270);
      5'd5:  return CW'(7723);
      5'd6:  return CW'(9102);
      5'd7:  return CW'(10394);
      5'd8:  return CW'(11585);
      5'd9:  return CW'(12665);
      5'd10: return CW'(13623);
      5'd11: return CW'(14449);
      5'd12: return CW'(15137);
      5'd13: return CW'(15679);
      5'd14: return CW'(16069);
      5'd15: return CW'(16305);
      default: return CW'(16384);
    endcase
  endfunction

  // sin(2*pi*e/64)
  function automatic logic signed [CW-1:0] sin64(input logic [EXPW-1:0] e);
    logic [4:0] r, rm;
    r  = {1'b0, e[3:0]};
    rm = 5'd16 - r;
    case (e[5:4])
      2'd0:    return quarter_sin(r);
      2'd1:    return quarter_sin(rm);
      2'd2:    return -quarter_sin(r);
      default: return -quarter_sin(rm);
    endcase
  endfunction

  function automatic logic signed [CW-1:0] cos64(input logic [EXPW-1:0] e);
    return sin64(e + EXPW'(16));
  endfunction

  // buffer slot t <- input sample index (first-stage gather order)
  function automatic logic [EXPW-1:0] src_load(input int t);
    return EXPW'(16 * (t % 4) + 4 * (t / 16) + (t / 4) % 4);
  endfunction

  // buffer slot t for stage s+1 <- result slot of stage s
  function automatic logic [EXPW-1:0] src_wback(input int s, input int t);
    if (s == 0) return EXPW'(16 * (t % 4) + 4 * ((t / 4) % 4) + t / 16);
    return EXPW'(16 * (t / 16) + 4 * (t % 4) + (t / 4) % 4);
  endfunction

  // natural output n <- final result slot (base-4 digit reversal)
  function automatic logic [EXPW-1:0] src_out(input int n);
    return EXPW'(16 * (n % 4) + 4 * ((n / 4) % 4) + n / 16);
  endfunction
endpackage

// File: rtl/fold4_ifft_ctrl.sv
module fold4_ifft_ctrl
  import fold4_ifft_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            out_ready,
  output logic            in_ready,
  output logic            out_valid,
  output logic            busy,
  output logic [STGW-1:0] stage,
  output logic [IDXW-1:0] idx,
  output logic            accept,
  output logic            adv,
  output logic            wback,
  output logic            fin
);
  logic last_bf, stall, idx_end;

  assign accept  = in_valid & in_ready;
  assign idx_end = (idx == IDXW'(NBF - 1));
  assign last_bf = busy & idx_end & (stage == STGW'(NSTG - 1));
  assign stall   = last_bf & out_valid & ~out_ready;
  assign adv     = busy & ~stall;
  assign wback   = adv & idx_end & (stage != STGW'(NSTG - 1));
  assign fin     = adv & last_bf;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      in_ready  <= 1'b1;
      stage     <= '0;
      idx       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (accept) begin
        busy     <= 1'b1;
        in_ready <= 1'b0;
        stage    <= '0;
        idx      <= '0;
      end else if (adv) begin
        idx <= idx + 1'b1;
        if (idx_end) begin
          if (stage == STGW'(NSTG - 1)) begin
            stage    <= '0;
            busy     <= 1'b0;
            in_ready <= 1'b1;
          end else begin
            stage <= stage + 1'b1;
          end
        end
      end
      if (fin) out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready); // R2
  AST_DONE_RAISES_VALID: assert property (@(posedge clk) disable iff (rst)
    fin |=> out_valid); // R4
  AST_DONE_REOPENS_INPUT: assert property (@(posedge clk) disable iff (rst)
    fin |=> in_ready); // R10
  AST_STALL_KEEPS_BUSY: assert property (@(posedge clk) disable iff (rst)
    stall |=> busy && !in_ready && out_valid); // R7
  AST_TAKEN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !fin |=> !out_valid); // R8
  AST_STAGE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    stage <= STGW'(NSTG - 1)); // R4
endmodule

// File: rtl/fold4_ifft_twid.sv
module fold4_ifft_twid
  import fold4_ifft_pkg::*;
(
  input  logic [STGW-1:0] stage,
  input  logic [IDXW-1:0] idx,
  output cplx_t           w [RADIX-1]
);
  logic [EXPW-1:0] step;

  always_comb begin
    step = '0;
    for (int s = 0; s < NSTG; s++) begin
      if (stage == STGW'(s))
        step = EXPW'((int'(idx) % (NBF >> (2 * s))) << (2 * s));
    end
  end

  for (genvar q = 1; q < RADIX; q++) begin : g_w
    logic [EXPW-1:0] e;
    always_comb begin
      e           = step * EXPW'(q);
      w[q-1].re   = cos64(e);
      w[q-1].im   = sin64(e);
    end
  end
endmodule

// File: rtl/fold4_ifft_bfly.sv
module fold4_ifft_bfly
  import fold4_ifft_pkg::*;
(
  input  cplx_t a [RADIX],
  input  cplx_t w [RADIX-1],
  output cplx_t y [RADIX]
);
  localparam int AW = DW + 2;
  localparam int PW = DW + CW + 1;
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (CFRAC - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic signed [AW-1:0] ar [RADIX];
  logic signed [AW-1:0] ai [RADIX];
  logic signed [AW-1:0] sr [RADIX];
  logic signed [AW-1:0] si [RADIX];
  logic signed [DW-1:0] hr [RADIX];
  logic signed [DW-1:0] hi [RADIX];
  logic signed [AW-1:0] t0r, t0i, t1r, t1i, t2r, t2i, t3r, t3i;

  always_comb begin
    for (int m = 0; m < RADIX; m++) begin
      ar[m] = AW'(a[m].re);
      ai[m] = AW'(a[m].im);
    end
    t0r = ar[0] + ar[2];  t0i = ai[0] + ai[2];
    t1r = ar[0] - ar[2];  t1i = ai[0] - ai[2];
    t2r = ar[1] + ar[3];  t2i = ai[1] + ai[3];
    t3r = ar[1] - ar[3];  t3i = ai[1] - ai[3];
    sr[0] = t0r + t2r;    si[0] = t0i + t2i;
    sr[2] = t0r - t2r;    si[2] = t0i - t2i;
    sr[1] = t1r - t3i;    si[1] = t1i + t3r;
    sr[3] = t1r + t3i;    si[3] = t1i - t3r;
    for (int m = 0; m < RADIX; m++) begin
      hr[m] = sr[m][AW-1:2];
      hi[m] = si[m][AW-1:2];
    end
    y[0].re = hr[0];
    y[0].im = hi[0];
  end

  for (genvar q = 1; q < RADIX; q++) begin : g_rot
    logic signed [PW-1:0] xr, xi, cr, ci, pr, pi;
    always_comb begin
      xr = PW'(hr[q]);
      xi = PW'(hi[q]);
      cr = PW'(w[q-1].re);
      ci = PW'(w[q-1].im);
      pr = (xr * cr - xi * ci + RND) >>> CFRAC;
      pi = (xr * ci + xi * cr + RND) >>> CFRAC;
      if (pr > MAXV)      y[q].re = MAXV[DW-1:0];
      else if (pr < MINV) y[q].re = MINV[DW-1:0];
      else                y[q].re = pr[DW-1:0];
      if (pi > MAXV)      y[q].im = MAXV[DW-1:0];
      else if (pi < MINV) y[q].im = MINV[DW-1:0];
      else                y[q].im = pi[DW-1:0];
    end
  end
endmodule

// File: rtl/fold4_ifft64.sv
module fold4_ifft64
  import fold4_ifft_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [BUSW-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [BUSW-1:0] out_data
);
  logic            busy, accept, adv, wback, fin;
  logic [STGW-1:0] stage;
  logic [IDXW-1:0] idx;

  cplx_t insmp [NPT];
  cplx_t sbuf  [NPT];
  cplx_t rbuf  [NPT];
  cplx_t mrg   [NPT];
  cplx_t wbv   [NPT];
  cplx_t odata [NPT];
  cplx_t opnd  [RADIX];
  cplx_t bres  [RADIX];
  cplx_t tw    [RADIX-1];

  fold4_ifft_ctrl u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .busy(busy),
    .stage(stage), .idx(idx), .accept(accept), .adv(adv),
    .wback(wback), .fin(fin)
  );

  fold4_ifft_twid u_twid (.stage(stage), .idx(idx), .w(tw));

  fold4_ifft_bfly u_bfly (.a(opnd), .w(tw), .y(bres));

  always_comb begin
    for (int k = 0; k < NPT; k++) insmp[k] = in_data[k*SW +: SW];
  end

  // four 16-way operand selectors
  always_comb begin
    for (int m = 0; m < RADIX; m++)
      opnd[m] = sbuf[{idx, LANEW'(m)}];
  end

  // results so far with the current butterfly's outputs merged in
  always_comb begin
    for (int t = 0; t < NPT; t++)
      mrg[t] = (idx == IDXW'(t / RADIX)) ? bres[LANEW'(t % RADIX)] : rbuf[t];
  end

  // inter-stage reorder for the stage being finished
  always_comb begin
    for (int t = 0; t < NPT; t++) begin
      wbv[t] = mrg[src_wback(0, t)];
      for (int s = 1; s < NSTG - 1; s++)
        if (stage == STGW'(s)) wbv[t] = mrg[src_wback(s, t)];
    end
  end

  // result steering into four slots of the result register
  always_ff @(posedge clk) begin
    if (adv) begin
      for (int m = 0; m < RADIX; m++)
        rbuf[{idx, LANEW'(m)}] <= bres[m];
    end
  end

  // symbol buffer: fresh input or recirculated data
  always_ff @(posedge clk) begin
    for (int t = 0; t < NPT; t++) begin
      if (accept)     sbuf[t] <= insmp[src_load(t)];
      else if (wback) sbuf[t] <= wbv[t];
    end
  end

  always_ff @(posedge clk) begin
    if (fin) begin
      for (int n = 0; n < NPT; n++) odata[n] <= mrg[src_out(n)];
    end
  end

  always_comb begin
    for (int n = 0; n < NPT; n++) out_data[n*SW +: SW] = odata[n];
  end

  AST_HELD_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R6
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !accept); // R3
endmodule

// File: tb/tb_fold4_ifft64.sv
`timescale 1ns/1ps
module tb_fold4_ifft64;
  localparam int NP = 64;
  localparam int BW = NP * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [BW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [BW-1:0] out_data;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fold4_ifft64 dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  // behavioural reference of the handshake timing
  bit            m_rdy, m_ov, m_busy, m_done;
  int            m_cnt;
  logic [BW-1:0] pend_sym;
  string         pend_tag, cur_tag;
  logic [BW-1:0] outq[$];
  string         tagq[$];

  always @(posedge clk) begin
    if (rst) begin
      m_rdy <= 1'b1; m_ov <= 1'b0; m_busy <= 1'b0; m_cnt <= 0;
      outq.delete(); tagq.delete();
    end else begin
      m_done = m_busy && (m_cnt == 47) && !(m_ov && !out_ready);
      if (m_ov && out_ready && outq.size() > 0) begin
        void'(outq.pop_front()); void'(tagq.pop_front());
      end
      if (in_valid && m_rdy) begin
        m_busy <= 1'b1; m_rdy <= 1'b0; m_cnt <= 0;
        pend_sym = in_data; pend_tag = cur_tag;
      end else if (m_busy) begin
        if (m_done) begin
          m_busy <= 1'b0; m_rdy <= 1'b1;
          outq.push_back(pend_sym); tagq.push_back(pend_tag);
        end else if (m_cnt != 47) begin
          m_cnt <= m_cnt + 1;
        end
      end
      m_ov <= m_done ? 1'b1 : (out_ready ? 1'b0 : m_ov);
    end
  end

  function automatic int part(input logic [BW-1:0] v, input int k, input bit re);
    return re ? int'($signed(v[k*32+16 +: 16])) : int'($signed(v[k*32 +: 16]));
  endfunction

  task automatic check_data(input logic [BW-1:0] got, input logic [BW-1:0] src, input string tag);
    bit bad = 1'b0;
    checks++;
    for (int n = 0; n < NP; n++) begin
      real er = 0.0, ei = 0.0;
      for (int k = 0; k < NP; k++) begin
        real ang = 2.0 * 3.14159265358979 * real'((n * k) % NP) / 64.0;
        real xr = real'(part(src, k, 1'b1));
        real xi = real'(part(src, k, 1'b0));
        er += xr * $cos(ang) - xi * $sin(ang);
        ei += xr * $sin(ang) + xi * $cos(ang);
      end
      er /= 64.0; ei /= 64.0;
      if (!bad && ((real'(part(got, n, 1'b1)) - er > 3.0) || (er - real'(part(got, n, 1'b1)) > 3.0) ||
                   (real'(part(got, n, 1'b0)) - ei > 3.0) || (ei - real'(part(got, n, 1'b0)) > 3.0))) begin
        bad = 1'b1;
        $display("FAIL %s sample %0d got (%0d,%0d) expected (%0.2f,%0.2f)",
                 tag, n, part(got, n, 1'b1), part(got, n, 1'b0), er, ei);
      end
    end
    if (bad) fails++;
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (in_ready !== m_rdy) begin
        fails++;
        $display("FAIL R2 R10 in_ready got %0b expected %0b", in_ready, m_rdy);
      end
      checks++;
      if (out_valid !== m_ov) begin
        fails++;
        $display("FAIL R4 R8 out_valid got %0b expected %0b", out_valid, m_ov);
      end
      if (out_valid && outq.size() > 0)
        check_data(out_data, outq[0], out_ready ? tagq[0] : "R6");
    end
  end

  task automatic send(input logic [BW-1:0] sym, input string tag);
    @(negedge clk);
    cur_tag  = tag;
    in_valid = 1'b1;
    in_data  = sym;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  logic [31:0] seed = 32'h1234_5678;
  function automatic logic [15:0] rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return 16'(int'(seed[30:16] % 15'd8000) - 4000);
  endfunction

  function automatic logic [BW-1:0] rand_sym();
    logic [BW-1:0] v;
    for (int k = 0; k < NP; k++) v[k*32 +: 32] = {rnd16(), rnd16()};
    return v;
  endfunction

  function automatic logic [BW-1:0] tone(input int bin, input int amp);
    logic [BW-1:0] v = '0;
    v[bin*32 +: 32] = {16'(amp), 16'(0)};
    return v;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog expired got hung expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state got ready=%0b valid=%0b expected ready=1 valid=0", in_ready, out_valid);
    end

    // impulse in bin 0: every output equals 6400/64
    send(tone(0, 6400), "R9");
    repeat (55) @(negedge clk);

    // tone with junk offered while busy
    send(tone(5, 4000), "R3");
    in_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      in_data = rand_sym();
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (40) @(negedge clk);

    // back-to-back pseudo-random symbols
    for (int i = 0; i < 3; i++) send(rand_sym(), "R5");
    repeat (55) @(negedge clk);

    // result waits, next symbol completes behind it
    out_ready = 1'b0;
    send(rand_sym(), "R7");
    while (!out_valid) @(negedge clk);
    send(rand_sym(), "R7");
    repeat (60) @(negedge clk);
    checks++;
    if (in_ready !== 1'b0 || out_valid !== 1'b1) begin
      fails++;
      $display("FAIL R7 stall got ready=%0b valid=%0b expected ready=0 valid=1", in_ready, out_valid);
    end
    out_ready = 1'b1;
    repeat (10) @(negedge clk);

    send('0, "R5");
    repeat (60) @(negedge clk);

    summary();
    $finish;
  end
endmodule